// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery and Claim Unit

This unit sits between the per-source interrupt state of a wired-mode interrupt controller and the harts it serves. The source logic supplies, for every source, its pending bit, its enable bit, the current level of its input line, its trigger sense and a target (hart index plus priority). For each hart, the unit searches all sources for the best candidate that is pending, enabled and aimed at that hart. Numerically smaller priority wins. A tie goes to the smaller source number. A per-hart threshold can cut off low-urgency sources. The result is registered as a per-hart "top" word, which in turn drives one level interrupt line per hart.

Software sees a 32-byte window per hart. The window holds a delivery switch, a force bit, the threshold, a read-only view of the top word, and a claim location. Reading the claim location returns the top word and, in the same cycle, sends the source logic a one-hot request to clear that source's pending bit. If the source is level-sensitive and its line is still asserted, a one-hot request to set the bit again is sent as well, so the source is re-armed at once. A claim that finds nothing returns zero and drops the force bit.

Top module: `hart_irq_deliver`

## Requirements
- R1: Register address is {hart index, 5-bit offset}. The offsets are 0x00 delivery enable, 0x04 force, 0x08 threshold, 0x18 top (read-only) and 0x1C claim (read). Any other offset reads 0 and ignores writes.
- R2: The delivery enable and force registers hold only write-data bit 0. The threshold holds only the low PRIO_W bits. All unused read bits return 0.
- R3: A source takes part in a hart's search only if it is pending, enabled and its target hart index equals that hart. Source 0 never takes part.
- R4: The smallest priority value wins. When priorities are equal, the smallest source number wins.
- R5: A target priority field of zero is treated as priority 1.
- R6: A non-zero threshold removes every source whose priority is greater than or equal to it. A threshold of zero removes nothing.
- R7: The top word carries the source number in bits 25:16 and the priority in bits 7:0, with all other bits zero. It is zero when no source qualifies, and it reflects its inputs one clock after they change.
- R8: A hart's interrupt line is high exactly when the domain enable is set, that hart's delivery enable is set, and either its force bit is set or its top word is non-zero.
- R9: A claim read returns the hart's registered top word. In that same cycle, pendClr is one-hot at the returned source number.
- R10: During a claim, pendSet is raised for the returned source if that source is level-high with its input at 1, or level-low with its input at 0. Otherwise pendSet stays zero.
- R11: A claim with a zero top word returns 0, raises no pendClr bit, and clears that hart's force bit.
- R12: After reset, all per-hart registers and top words are zero and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| domainEn | input | 1 | Domain-wide interrupt enable |
| srcPend | input | NSRC | Pending bit per source (bit 0 unused) |
| srcEn | input | NSRC | Enable bit per source |
| srcIn | input | NSRC | Current input level per source |
| srcLvlHi | input | NSRC | Source is level-triggered, active high |
| srcLvlLo | input | NSRC | Source is level-triggered, active low |
| tgtHartFlat | input | NSRC*HART_W | Target hart index per source, source s at [s*HART_W +: HART_W] |
| tgtPrioFlat | input | NSRC*PRIO_W | Target priority per source, source s at [s*PRIO_W +: PRIO_W] |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | HART_W+5 | {hart index, byte offset} |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRd |
| irqOut | output | NHART | Level interrupt per hart |
| pendClr | output | NSRC | One-hot pending-clear request on claim |
| pendSet | output | NSRC | Pending re-set request for level sources on claim |

## Verification
On every cycle, the assertions check the shape of the claim side effects: pendClr is one-hot and never touches source 0, and it appears only during a claim read. pendSet is a subset of pendClr. An empty claim clears nothing. They also check that no interrupt line is high while the domain is off, and that the read-data fields carry no stray bits. The search itself can only be shown by the bench's scenarios, which need known pending and priority patterns. This covers the priority order and the tie rule, the zero-priority promotion, threshold cut-offs and hart routing. The same holds for the one-cycle latency of the top word, re-arming against the live input level, and force clearing on an empty claim.

// File: rtl/hd_pkg.sv
`timescale 1ns/1ps
package hd_pkg;
  localparam logic [4:0] OFS_DELIV  = 5'h00;
  localparam logic [4:0] OFS_FORCE  = 5'h04;
  localparam logic [4:0] OFS_THRESH = 5'h08;
  localparam logic [4:0] OFS_TOP    = 5'h18;
  localparam logic [4:0] OFS_CLAIM  = 5'h1C;
  localparam int TOP_ID_LSB = 16;
  localparam int TOP_ID_W   = 10;

  // strobes from register decode to datapath
  typedef struct packed {
    logic wrDeliv;
    logic wrForce;
    logic wrThresh;
    logic rdDeliv;
    logic rdForce;
    logic rdThresh;
    logic rdTop;
    logic rdClaim;
  } strobe_t;
endpackage

// File: rtl/hd_ctrl.sv
`timescale 1ns/1ps
module hd_ctrl import hd_pkg::*; #(
  parameter int NHART  = 2,
  parameter int HART_W = 1,
  parameter int ADDR_W = HART_W + 5
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output logic [HART_W-1:0] hartSel
);
  logic [4:0] ofs;
  logic       hartHit;
  logic       wrOk;
  logic       rdOk;

  assign ofs     = busAddr[4:0];
  assign hartSel = busAddr[ADDR_W-1:5];
  assign hartHit = int'(hartSel) < NHART;
  assign wrOk    = busWr && hartHit;
  assign rdOk    = busRd && hartHit;

  always_comb begin
    stb = '0;
    stb.wrDeliv  = wrOk && (ofs == OFS_DELIV);
    stb.wrForce  = wrOk && (ofs == OFS_FORCE);
    stb.wrThresh = wrOk && (ofs == OFS_THRESH);
    stb.rdDeliv  = rdOk && (ofs == OFS_DELIV);
    stb.rdForce  = rdOk && (ofs == OFS_FORCE);
    stb.rdThresh = rdOk && (ofs == OFS_THRESH);
    stb.rdTop    = rdOk && (ofs == OFS_TOP);
    stb.rdClaim  = rdOk && (ofs == OFS_CLAIM);
  end
endmodule

// File: rtl/hd_tree.sv
`timescale 1ns/1ps
module hd_tree #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 3,
  parameter int ID_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             qual,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]           thresh,
  output logic                        bestV,
  output logic [ID_W-1:0]             bestId,
  output logic [PRIO_W-1:0]           bestPrio
);
  localparam int LEAVES = 1 << ID_W;
  localparam int NODES  = 2 * LEAVES - 1;

  logic              nV [NODES];
  logic [ID_W-1:0]   nI [NODES];
  logic [PRIO_W-1:0] nP [NODES];
  logic              unusedSrc0;

  assign unusedSrc0 = qual[0] ^ (^prio[0]);

  genvar g;
  for (g = 0; g < LEAVES; g++) begin : g_leaf
    localparam int N = LEAVES - 1 + g;
    if (g < NSRC && g != 0) begin : g_real
      assign nV[N] = qual[g] && ((thresh == '0) || (prio[g] < thresh));
      assign nP[N] = prio[g];
      assign nI[N] = ID_W'(g);
    end else begin : g_pad
      assign nV[N] = 1'b0;
      assign nP[N] = '0;
      assign nI[N] = '0;
    end
  end

  // heap order keeps lower source numbers on the left: ties go left
  for (g = 0; g < LEAVES - 1; g++) begin : g_node
    logic pickL;
    assign pickL = nV[2*g+1] && (!nV[2*g+2] || (nP[2*g+1] <= nP[2*g+2]));
    assign nV[g] = nV[2*g+1] || nV[2*g+2];
    assign nI[g] = pickL ? nI[2*g+1] : nI[2*g+2];
    assign nP[g] = pickL ? nP[2*g+1] : nP[2*g+2];
  end

  assign bestV    = nV[0];
  assign bestId   = nI[0];
  assign bestPrio = nP[0];
endmodule

// File: rtl/hd_datapath.sv
`timescale 1ns/1ps
module hd_datapath import hd_pkg::*; #(
  parameter int NSRC   = 16,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3,
  parameter int HART_W = 1,
  parameter int ID_W   = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [HART_W-1:0]           hartSel,
  input  logic [31:0]                 busWdata,
  input  logic                        domainEn,
  input  logic [NSRC-1:0]             srcPend,
  input  logic [NSRC-1:0]             srcEn,
  input  logic [NSRC-1:0]             srcIn,
  input  logic [NSRC-1:0]             srcLvlHi,
  input  logic [NSRC-1:0]             srcLvlLo,
  input  logic [NSRC-1:0][HART_W-1:0] tgtHart,
  input  logic [NSRC-1:0][PRIO_W-1:0] tgtPrio,
  output logic [31:0]                 busRdata,
  output logic [NHART-1:0]            irqOut,
  output logic [NSRC-1:0]             pendClr,
  output logic [NSRC-1:0]             pendSet
);
  logic [NSRC-1:0][PRIO_W-1:0] effPrio;
  logic [NHART-1:0]            delivR;
  logic [NHART-1:0]            forceR;
  logic [PRIO_W-1:0]           threshR  [NHART];
  logic [NHART-1:0]            topV;
  logic [ID_W-1:0]             topId    [NHART];
  logic [PRIO_W-1:0]           topPrio  [NHART];
  logic [NHART-1:0]            nxtV;
  logic [ID_W-1:0]             nxtId    [NHART];
  logic [PRIO_W-1:0]           nxtPrio  [NHART];
  logic [31:0]                 topWord  [NHART];
  logic                        unusedWdata;

  assign unusedWdata = ^busWdata[31:PRIO_W];

  // zero priority is promoted to 1
  for (genvar s = 0; s < NSRC; s++) begin : g_prio
    assign effPrio[s] = (tgtPrio[s] == '0) ? PRIO_W'(1) : tgtPrio[s];
  end

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    logic [NSRC-1:0] match;
    logic [NSRC-1:0] qual;
    for (genvar s = 0; s < NSRC; s++) begin : g_match
      assign match[s] = (tgtHart[s] == HART_W'(h));
    end
    assign qual = srcPend & srcEn & match;

    hd_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
      .qual    (qual),
      .prio    (effPrio),
      .thresh  (threshR[h]),
      .bestV   (nxtV[h]),
      .bestId  (nxtId[h]),
      .bestPrio(nxtPrio[h])
    );

    assign topWord[h] = topV[h] ?
      {6'b0, TOP_ID_W'(topId[h]), 8'b0, 8'(topPrio[h])} : 32'b0;
    assign irqOut[h] = domainEn && delivR[h] && (forceR[h] || topV[h]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delivR <= '0;
      forceR <= '0;
      topV   <= '0;
      for (int h = 0; h < NHART; h++) begin
        threshR[h] <= '0;
        topId[h]   <= '0;
        topPrio[h] <= '0;
      end
    end else begin
      topV <= nxtV;
      for (int h = 0; h < NHART; h++) begin
        topId[h]   <= nxtId[h];
        topPrio[h] <= nxtPrio[h];
        if (hartSel == HART_W'(h)) begin
          if (stb.wrDeliv)  delivR[h]  <= busWdata[0];
          if (stb.wrThresh) threshR[h] <= busWdata[PRIO_W-1:0];
          if (stb.wrForce)
            forceR[h] <= busWdata[0];
          else if (stb.rdClaim && !topV[h])
            forceR[h] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    busRdata = 32'b0;
    if (stb.rdDeliv)  busRdata = {31'b0, delivR[hartSel]};
    if (stb.rdForce)  busRdata = {31'b0, forceR[hartSel]};
    if (stb.rdThresh) busRdata = {{(32-PRIO_W){1'b0}}, threshR[hartSel]};
    if (stb.rdTop || stb.rdClaim) busRdata = topWord[hartSel];
  end

  always_comb begin
    pendClr = '0;
    if (stb.rdClaim && topV[hartSel]) pendClr[topId[hartSel]] = 1'b1;
  end
  assign pendSet = pendClr & ((srcLvlHi & srcIn) | (srcLvlLo & ~srcIn));
endmodule

// File: rtl/hart_irq_deliver.sv
`timescale 1ns/1ps
module hart_irq_deliver import hd_pkg::*; #(
  parameter int NSRC   = 16,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3,
  localparam int HART_W = (NHART > 1) ? $clog2(NHART) : 1,
  localparam int ID_W   = $clog2(NSRC),
  localparam int ADDR_W = HART_W + 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     domainEn,
  input  logic [NSRC-1:0]          srcPend,
  input  logic [NSRC-1:0]          srcEn,
  input  logic [NSRC-1:0]          srcIn,
  input  logic [NSRC-1:0]          srcLvlHi,
  input  logic [NSRC-1:0]          srcLvlLo,
  input  logic [NSRC*HART_W-1:0]   tgtHartFlat,
  input  logic [NSRC*PRIO_W-1:0]   tgtPrioFlat,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  output logic [NHART-1:0]         irqOut,
  output logic [NSRC-1:0]          pendClr,
  output logic [NSRC-1:0]          pendSet
);
  strobe_t                     stb;
  logic [HART_W-1:0]           hartSel;
  logic [NSRC-1:0][HART_W-1:0] tgtHart;
  logic [NSRC-1:0][PRIO_W-1:0] tgtPrio;

  for (genvar s = 0; s < NSRC; s++) begin : g_unflat
    assign tgtHart[s] = tgtHartFlat[s*HART_W +: HART_W];
    assign tgtPrio[s] = tgtPrioFlat[s*PRIO_W +: PRIO_W];
  end

  hd_ctrl #(.NHART(NHART), .HART_W(HART_W), .ADDR_W(ADDR_W)) u_ctrl (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .stb    (stb),
    .hartSel(hartSel)
  );

  hd_datapath #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W),
                .HART_W(HART_W), .ID_W(ID_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .hartSel (hartSel),
    .busWdata(busWdata),
    .domainEn(domainEn),
    .srcPend (srcPend),
    .srcEn   (srcEn),
    .srcIn   (srcIn),
    .srcLvlHi(srcLvlHi),
    .srcLvlLo(srcLvlLo),
    .tgtHart (tgtHart),
    .tgtPrio (tgtPrio),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .pendClr (pendClr),
    .pendSet (pendSet)
  );
endmodule

// File: rtl/hd_check.sv
`timescale 1ns/1ps
module hd_check #(
  parameter int NSRC   = 16,
  parameter int NHART  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              domainEn,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic [NHART-1:0]  irqOut,
  input logic [NSRC-1:0]   pendClr,
  input logic [NSRC-1:0]   pendSet
);
  logic rdTopLike;
  assign rdTopLike = busRd && (busAddr[4:0] == 5'h18 || busAddr[4:0] == 5'h1C);

  p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClr));
  p_clr_only_on_claim_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr != '0) |-> (busRd && busAddr[4:0] == 5'h1C));
  p_src0_never_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pendClr[0]);
  p_set_within_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendSet & ~pendClr) == '0);
  p_empty_claim_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[4:0] == 5'h1C && busRdata == 32'b0) |-> (pendClr == '0));
  p_irq_needs_domain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> domainEn);
  p_thresh_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[4:0] == 5'h08) |-> (busRdata[31:PRIO_W] == '0));
  p_flag_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busAddr[4:0] == 5'h00 || busAddr[4:0] == 5'h04)) |->
      (busRdata[31:1] == '0));
  p_top_format_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdTopLike |-> (busRdata[31:26] == '0 && busRdata[15:PRIO_W] == '0));
  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0));
endmodule

bind hart_irq_deliver hd_check #(
  .NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .domainEn(domainEn),
  .busRd   (busRd),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .pendClr (pendClr),
  .pendSet (pendSet)
);

// File: tb/sim_hart_irq_deliver.sv
`timescale 1ns/1ps
module sim_hart_irq_deliver;
  localparam int NSRC = 16, NHART = 2, PRIO_W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        domainEn = 1'b1;
  logic [15:0] srcPend;
  logic [15:0] srcEn = '0, srcIn = '0, srcLvlHi = '0, srcLvlLo = '0;
  logic [15:0] tgtHart = '0;
  logic [47:0] tgtPrio = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irqOut;
  logic [15:0] pendClr, pendSet;
  logic [15:0] setReq = '0;

  int total = 0, bad = 0;
  bit ended = 1'b0;
  string       qReq[$];
  logic [31:0] qExp[$];

  always #10 clk = ~clk;

  hart_irq_deliver #(.NSRC(NSRC), .NHART(NHART), .PRIO_W(PRIO_W)) u0 (
    .clk(clk), .rstN(rstN), .domainEn(domainEn), .srcPend(srcPend),
    .srcEn(srcEn), .srcIn(srcIn), .srcLvlHi(srcLvlHi), .srcLvlLo(srcLvlLo),
    .tgtHartFlat(tgtHart), .tgtPrioFlat(tgtPrio), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .pendClr(pendClr), .pendSet(pendSet));

  // model of the source-side pending bits
  always @(posedge clk)
    if (!rstN) srcPend <= '0;
    else       srcPend <= (srcPend & ~pendClr) | pendSet | setReq;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] topw(int id, int p);
    return (32'(id) << 16) | 32'(p);
  endfunction

  // monitor: compares every read against the scoreboard queue
  initial forever begin
    @(negedge clk); #5;
    if (busRd) begin
      if (qExp.size() == 0) chk("scoreboard-empty", busRdata, 32'hx);
      else chk(qReq.pop_front(), busRdata, qExp.pop_front());
    end
  end

  task automatic wr(int h, logic [4:0] ofs, logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = {h[0], ofs}; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(int h, logic [4:0] ofs, logic [31:0] exp, string req);
    @(negedge clk); busRd = 1'b1; busAddr = {h[0], ofs};
    qExp.push_back(exp); qReq.push_back(req);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic raise(int s);
    @(negedge clk); setReq = 16'(1 << s);
    @(negedge clk); setReq = '0;
  endtask

  task automatic irqChk(int h, logic exp, string req);
    @(negedge clk); #5;
    chk(req, 32'(irqOut[h]), 32'(exp));
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    irqChk(0, 1'b0, "R12 irq0 after reset");
    rd(0, 5'h18, 32'h0, "R12 top0 after reset");
    rd(0, 5'h00, 32'h0, "R12 deliv0 after reset");
    // register widths
    wr(0, 5'h00, 32'hFFFF_FFFE);
    rd(0, 5'h00, 32'h0, "R2 deliv keeps bit0 only");
    wr(0, 5'h00, 32'h3);
    rd(0, 5'h00, 32'h1, "R2 deliv bit0");
    wr(0, 5'h08, 32'hFD);
    rd(0, 5'h08, 32'h5, "R2 threshold width");
    wr(0, 5'h08, 32'h0);
    wr(0, 5'h0C, 32'h1);
    rd(0, 5'h0C, 32'h0, "R1 unmapped offset");
    rd(0, 5'h04, 32'h0, "R1 force untouched");
    // search
    srcEn = 16'hFFFE;
    tgtPrio[3*3 +: 3] = 3'd5;
    raise(3);
    rd(0, 5'h18, topw(3, 5), "R7 top word format");
    irqChk(0, 1'b1, "R8 irq0 with top");
    rd(1, 5'h18, 32'h0, "R3 other hart empty");
    tgtPrio[5*3 +: 3] = 3'd2; raise(5);
    rd(0, 5'h18, topw(5, 2), "R4 smaller priority wins");
    tgtPrio[7*3 +: 3] = 3'd2; raise(7);
    rd(0, 5'h18, topw(5, 2), "R4 tie lowest source");
    raise(9);
    rd(0, 5'h18, topw(9, 1), "R5 zero priority as 1");
    srcEn[9] = 1'b0;
    rd(0, 5'h18, topw(5, 2), "R3 disabled source skipped");
    srcEn[9] = 1'b1;
    wr(0, 5'h08, 32'h2);
    rd(0, 5'h18, topw(9, 1), "R6 threshold 2");
    wr(0, 5'h08, 32'h1);
    rd(0, 5'h18, 32'h0, "R6 threshold 1 excludes all");
    irqChk(0, 1'b0, "R8 irq0 low with empty top");
    wr(0, 5'h08, 32'h0);
    // routing and line gating
    tgtHart[9] = 1'b1;
    rd(0, 5'h18, topw(5, 2), "R3 rerouted away");
    rd(1, 5'h18, topw(9, 1), "R3 rerouted to hart1");
    irqChk(1, 1'b0, "R8 irq1 delivery off");
    wr(1, 5'h00, 32'h1);
    irqChk(1, 1'b1, "R8 irq1 delivery on");
    domainEn = 1'b0;
    irqChk(0, 1'b0, "R8 domain off irq0");
    irqChk(1, 1'b0, "R8 domain off irq1");
    domainEn = 1'b1;
    // claims
    rd(1, 5'h1C, topw(9, 1), "R9 claim edge source");
    rd(1, 5'h18, 32'h0, "R9 edge source cleared");
    irqChk(1, 1'b0, "R8 irq1 after claim");
    wr(1, 5'h04, 32'h1);
    irqChk(1, 1'b1, "R8 force raises irq1");
    rd(1, 5'h04, 32'h1, "R2 force bit");
    rd(1, 5'h1C, 32'h0, "R11 empty claim");
    rd(1, 5'h04, 32'h0, "R11 force cleared");
    irqChk(1, 1'b0, "R11 irq1 low");
    srcLvlHi[5] = 1'b1; srcIn[5] = 1'b1;
    rd(0, 5'h1C, topw(5, 2), "R10 claim level-high");
    rd(0, 5'h18, topw(5, 2), "R10 level-high rearmed");
    srcIn[5] = 1'b0;
    rd(0, 5'h1C, topw(5, 2), "R10 claim level-high idle");
    rd(0, 5'h18, topw(7, 2), "R10 level-high not rearmed");
    srcLvlLo[7] = 1'b1; srcIn[7] = 1'b0;
    rd(0, 5'h1C, topw(7, 2), "R10 claim level-low");
    rd(0, 5'h18, topw(7, 2), "R10 level-low rearmed");
    srcIn[7] = 1'b1;
    rd(0, 5'h1C, topw(7, 2), "R10 claim level-low idle");
    rd(0, 5'h18, topw(3, 5), "R9 next candidate");
    repeat (3) @(negedge clk);
    if (qExp.size() != 0) chk("scoreboard-drain", 32'(qExp.size()), 32'h0);
    finishRun();
  end
endmodule